// File: doc/BRIEF.md
# External Bus Clock and Ready Controller

This block produces the clock that leaves the chip on a general-purpose parallel bus. It also decides, cycle by cycle, whether the access in progress must wait for the far side. The internal clock phase advances on each pulse of a divided enable. The output clock follows that phase unless one of two gating controls holds it low. A forced gate holds the clock low at all times. An idle gate holds it low only between transactions, and only when the clock pin is in use and the divider count is non-zero. An invert control turns the output clock over, so that its rising edge lands in the middle of the outbound data window. The block also gives a one-cycle capture strobe that marks each rising edge of the output clock, which is the point where inbound data is taken.

A raw ready pin from the outside passes through a two-flop synchronizer and is then qualified by an enable and a polarity control. While the qualified ready says "not ready" during a transaction, the block asserts a stall to the access sequencer. All control inputs are plain configuration levels. With every control at zero, the clock runs freely, is not inverted, and never stalls.

Top module: `ebus_clkrdy_ctrl`

## Requirements
- R1: With `cfgForceGate` = 1, `extClk` is low from the second internal cycle on and stays low. With it back at 0 and no other gating, `extClk` toggles again within three cycles.
- R2: With `cfgIdleGate` = 1, `pinEnabled` = 1 and `divCountZero` = 0, `extClk` stays low while `xferActive` = 0 and toggles while `xferActive` = 1.
- R3: `cfgIdleGate` has no effect while `pinEnabled` = 0 or `divCountZero` = 1. In either case `extClk` runs freely.
- R4: With `cfgInvert` = 1, `extClk` is the complement of the ungated internal phase. In reset the phase is 0, so `extClk` reads 1 with invert set. Flipping `cfgInvert` flips an ungated `extClk` in the same cycle.
- R5: `captureStrobe` is 1 in exactly those cycles where `extClk` is 1 and was 0 in the cycle before.
- R6: With `cfgReadyEn` = 1 and `cfgReadyInv` = 0, `stallAccess` is 1 while the synchronized ready pin is low during a transaction.
- R7: With `cfgReadyEn` = 1 and `cfgReadyInv` = 1, `stallAccess` is 1 while the synchronized ready pin is high during a transaction.
- R8: With `cfgReadyEn` = 0, `stallAccess` stays 0 whatever the ready pin does.
- R9: In reset, with `cfgInvert` = 0, `extClk` = 0 and `stallAccess` = 0.
- R10: A change on `extReadyPin` reaches `stallAccess` on the third rising edge of `clk` after the change. This holds for both assertion and release: two synchronizer stages plus one stall register.
- R11: The gating state changes only on an edge where `extClk` was low before gating, so no shortened high pulse appears on `extClk`.
- R12: `stallAccess` is 1 only if `xferActive` was 1 in the cycle before.
- R13: The internal phase advances only on cycles with `phaseEn` = 1. While `phaseEn` = 0, an ungated `extClk` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseEn | input | 1 | Divided enable; advances the internal clock phase |
| cfgForceGate | input | 1 | Hold output clock low |
| cfgIdleGate | input | 1 | Hold output clock low between transactions |
| cfgInvert | input | 1 | Invert output clock |
| cfgReadyEn | input | 1 | Use external ready to stall accesses |
| cfgReadyInv | input | 1 | Ready pin is active-low when set |
| xferActive | input | 1 | A read or write transaction is in progress |
| pinEnabled | input | 1 | The clock pin is in use |
| divCountZero | input | 1 | The divider count is zero |
| extReadyPin | input | 1 | Raw asynchronous ready from the bus |
| extClk | output | 1 | Bus clock output |
| captureStrobe | output | 1 | Marks a rising edge of extClk |
| stallAccess | output | 1 | Current access must wait |

## Verification
The assertions check, on every cycle, these rules: a forced gate keeps a low clock low, the gating state changes only while the output is low, the capture strobe lines up with rising edges, and no stall appears without a transaction in the cycle before or with ready handling disabled. Other behaviours can only be shown by the bench's scenarios. These are the idle gate and the conditions that override it, the reset level under inversion, the immediate flip when inversion changes, the phase hold without an enable pulse, both ready polarities, and the exact three-edge latency from pin to stall.

// File: rtl/ebus_clkrdy_pkg.sv
package ebus_clkrdy_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic gateLoad;   // gating state may change on this edge
    logic gateValue;  // gating state to take when it may change
    logic stallNext;  // stall decision for the next cycle
  } ctlStrobe_t;

endpackage

// File: rtl/ebus_clkrdy_ctl.sv
module ebus_clkrdy_ctl
  import ebus_clkrdy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgForceGate,
  input  logic       cfgIdleGate,
  input  logic       cfgReadyEn,
  input  logic       cfgReadyInv,
  input  logic       xferActive,
  input  logic       pinEnabled,
  input  logic       divCountZero,
  input  logic       extReadyPin,
  input  logic       rawClkLow,
  output ctlStrobe_t strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic idleGateLive;
  logic readyOk;

  // Synchronizer chain for the asynchronous ready pin.
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      if (s == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= extReadyPin;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  // Idle gating only counts when the pin is in use and the divider runs.
  assign idleGateLive = cfgIdleGate & pinEnabled & ~divCountZero;

  // Ready polarity: with invert set, a high pin means "not ready".
  assign readyOk = syncQ[LAST] ^ cfgReadyInv;

  always_comb begin
    strobes.gateValue = cfgForceGate | (idleGateLive & ~xferActive);
    strobes.gateLoad  = rawClkLow;
    strobes.stallNext = cfgReadyEn & xferActive & ~readyOk;
  end

endmodule

// File: rtl/ebus_clkrdy_dp.sv
module ebus_clkrdy_dp
  import ebus_clkrdy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseEn,
  input  logic       cfgInvert,
  input  ctlStrobe_t strobes,
  output logic       rawClkLow,
  output logic       gateState,
  output logic       extClk,
  output logic       captureStrobe,
  output logic       stallAccess
);

  logic phaseQ;
  logic gateQ;
  logic stallQ;
  logic extClkDly;
  logic rawClk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
      gateQ  <= 1'b0;
      stallQ <= 1'b0;
    end else begin
      if (phaseEn)          phaseQ <= ~phaseQ;
      if (strobes.gateLoad) gateQ  <= strobes.gateValue;
      stallQ <= strobes.stallNext;
    end
  end

  // Tracks the output through reset, so the strobe is correct right after it.
  always_ff @(posedge clk) extClkDly <= extClk;

  assign rawClk        = phaseQ ^ cfgInvert;
  assign rawClkLow     = ~rawClk;
  assign gateState     = gateQ;
  assign extClk        = rawClk & ~gateQ;
  assign captureStrobe = extClk & ~extClkDly;
  assign stallAccess   = stallQ;

endmodule

// File: rtl/ebus_clkrdy_ctrl.sv
module ebus_clkrdy_ctrl
  import ebus_clkrdy_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic phaseEn,
  input  logic cfgForceGate,
  input  logic cfgIdleGate,
  input  logic cfgInvert,
  input  logic cfgReadyEn,
  input  logic cfgReadyInv,
  input  logic xferActive,
  input  logic pinEnabled,
  input  logic divCountZero,
  input  logic extReadyPin,
  output logic extClk,
  output logic captureStrobe,
  output logic stallAccess
);

  ctlStrobe_t strobes;
  logic rawClkLow;
  logic gateState;

  ebus_clkrdy_ctl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgForceGate (cfgForceGate),
    .cfgIdleGate  (cfgIdleGate),
    .cfgReadyEn   (cfgReadyEn),
    .cfgReadyInv  (cfgReadyInv),
    .xferActive   (xferActive),
    .pinEnabled   (pinEnabled),
    .divCountZero (divCountZero),
    .extReadyPin  (extReadyPin),
    .rawClkLow    (rawClkLow),
    .strobes      (strobes)
  );

  ebus_clkrdy_dp uDp (
    .clk           (clk),
    .rstN          (rstN),
    .phaseEn       (phaseEn),
    .cfgInvert     (cfgInvert),
    .strobes       (strobes),
    .rawClkLow     (rawClkLow),
    .gateState     (gateState),
    .extClk        (extClk),
    .captureStrobe (captureStrobe),
    .stallAccess   (stallAccess)
  );

endmodule

// File: rtl/ebus_clkrdy_chk.sv
module ebus_clkrdy_chk (
  input logic clk,
  input logic rstN,
  input logic cfgForceGate,
  input logic cfgReadyEn,
  input logic xferActive,
  input logic rawClkLow,
  input logic gateState,
  input logic extClk,
  input logic captureStrobe,
  input logic stallAccess
);

  assert_force_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cfgForceGate) && !$past(extClk)) |-> !extClk);

  assert_capture_edge_R5: assert property (@(posedge clk) disable iff (!rstN)
    captureStrobe |-> (extClk && !$past(extClk)));

  assert_ready_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgReadyEn) |-> !stallAccess);

  assert_gate_when_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (gateState != $past(gateState)) |-> $past(rawClkLow));

  assert_stall_needs_xfer_R12: assert property (@(posedge clk) disable iff (!rstN)
    stallAccess |-> $past(xferActive));

endmodule

bind ebus_clkrdy_ctrl ebus_clkrdy_chk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .cfgForceGate  (cfgForceGate),
  .cfgReadyEn    (cfgReadyEn),
  .xferActive    (xferActive),
  .rawClkLow     (rawClkLow),
  .gateState     (gateState),
  .extClk        (extClk),
  .captureStrobe (captureStrobe),
  .stallAccess   (stallAccess)
);

// File: tb/tb_ebus_clkrdy_ctrl.sv
module tb_ebus_clkrdy_ctrl;

  localparam int KIND_LOW    = 0;
  localparam int KIND_TOGGLE = 1;
  localparam int KIND_STALL  = 2;
  localparam int KIND_CLKVAL = 3;
  localparam int KIND_STABLE = 4;
  localparam int KIND_CAP    = 5;

  typedef struct {
    string tag;
    int    kind;
    bit    val;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseEn = 1'b1;
  logic cfgForceGate = 1'b0, cfgIdleGate = 1'b0, cfgInvert = 1'b0;
  logic cfgReadyEn = 1'b0, cfgReadyInv = 1'b0;
  logic xferActive = 1'b0, pinEnabled = 1'b0, divCountZero = 1'b0;
  logic extReadyPin = 1'b0;
  logic extClk, captureStrobe, stallAccess;

  item_t q[$];
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  logic prevClk = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ebus_clkrdy_ctrl dut (
    .clk(clk), .rstN(rstN), .phaseEn(phaseEn),
    .cfgForceGate(cfgForceGate), .cfgIdleGate(cfgIdleGate), .cfgInvert(cfgInvert),
    .cfgReadyEn(cfgReadyEn), .cfgReadyInv(cfgReadyInv),
    .xferActive(xferActive), .pinEnabled(pinEnabled), .divCountZero(divCountZero),
    .extReadyPin(extReadyPin),
    .extClk(extClk), .captureStrobe(captureStrobe), .stallAccess(stallAccess)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver side: push one expected item, then let the monitor consume it.
  task automatic expectItem(input string tag, input int kind, input bit val = 1'b0);
    item_t it;
    it.tag = tag; it.kind = kind; it.val = val;
    q.push_back(it);
    tick();
  endtask

  task automatic report(input string tag, input bit ok, input string what,
                        input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare one expected item per falling edge.
  always @(negedge clk) begin
    logic cur;
    item_t it;
    cur = extClk;
    if (q.size() > 0) begin
      it = q.pop_front();
      case (it.kind)
        KIND_LOW:    report(it.tag, cur == 1'b0, "extClk low", cur, 0);
        KIND_TOGGLE: report(it.tag, cur != prevClk, "extClk toggle", cur, !prevClk);
        KIND_STALL:  report(it.tag, stallAccess == it.val, "stallAccess", stallAccess, it.val);
        KIND_CLKVAL: report(it.tag, cur == it.val, "extClk value", cur, it.val);
        KIND_STABLE: report(it.tag, cur == prevClk, "extClk hold", cur, prevClk);
        KIND_CAP:    report(it.tag, captureStrobe == (cur & ~prevClk), "captureStrobe",
                            captureStrobe, cur & ~prevClk);
        default: ;
      endcase
    end
    prevClk = cur;
  end

  initial begin
    logic c0;
    // Reset state (R9) and reset level under inversion (R4)
    tick(3);
    expectItem("R9", KIND_CLKVAL, 1'b0);
    expectItem("R9", KIND_STALL, 1'b0);
    cfgInvert = 1'b1;
    tick();
    expectItem("R4", KIND_CLKVAL, 1'b1);
    cfgInvert = 1'b0;
    tick();
    rstN = 1'b1;
    tick(2);
    // Free running by default, capture strobe on rises (R1, R5)
    for (int i = 0; i < 4; i++) expectItem("R1", KIND_TOGGLE);
    for (int i = 0; i < 4; i++) expectItem("R5", KIND_CAP);
    // Phase holds without enable (R13)
    phaseEn = 1'b0;
    tick();
    for (int i = 0; i < 3; i++) expectItem("R13", KIND_STABLE);
    phaseEn = 1'b1;
    tick();
    expectItem("R13", KIND_TOGGLE);
    // Forced gate (R1)
    cfgForceGate = 1'b1;
    tick(2);
    for (int i = 0; i < 4; i++) expectItem("R1", KIND_LOW);
    cfgForceGate = 1'b0;
    tick(3);
    for (int i = 0; i < 3; i++) expectItem("R1", KIND_TOGGLE);
    // Idle gate (R2)
    cfgIdleGate = 1'b1; pinEnabled = 1'b1; divCountZero = 1'b0; xferActive = 1'b0;
    tick(3);
    for (int i = 0; i < 3; i++) expectItem("R2", KIND_LOW);
    xferActive = 1'b1;
    tick(3);
    for (int i = 0; i < 3; i++) expectItem("R2", KIND_TOGGLE);
    xferActive = 1'b0;
    tick(3);
    for (int i = 0; i < 2; i++) expectItem("R2", KIND_LOW);
    // Idle gate overridden (R3)
    pinEnabled = 1'b0;
    tick(3);
    for (int i = 0; i < 3; i++) expectItem("R3", KIND_TOGGLE);
    pinEnabled = 1'b1;
    tick(3);
    expectItem("R3", KIND_LOW);
    divCountZero = 1'b1;
    tick(3);
    for (int i = 0; i < 3; i++) expectItem("R3", KIND_TOGGLE);
    divCountZero = 1'b0; cfgIdleGate = 1'b0;
    tick(3);
    // Inversion flips the clock in the same cycle (R4)
    for (int k = 0; k < 2; k++) begin
      c0 = extClk;
      cfgInvert = ~cfgInvert;
      #1;
      expectItem("R4", KIND_CLKVAL, ~c0);
    end
    cfgInvert = 1'b1;
    tick();
    for (int i = 0; i < 3; i++) expectItem("R5", KIND_CAP);
    cfgForceGate = 1'b1;
    tick(2);
    for (int i = 0; i < 3; i++) expectItem("R11", KIND_LOW);
    cfgForceGate = 1'b0; cfgInvert = 1'b0;
    tick(3);
    // Ready active high (R6) and pin-to-stall latency (R10)
    xferActive = 1'b1; cfgReadyEn = 1'b1; cfgReadyInv = 1'b0; extReadyPin = 1'b1;
    tick(4);
    expectItem("R6", KIND_STALL, 1'b0);
    extReadyPin = 1'b0;
    tick(2);
    expectItem("R10", KIND_STALL, 1'b0);
    expectItem("R10", KIND_STALL, 1'b1);
    expectItem("R6", KIND_STALL, 1'b1);
    extReadyPin = 1'b1;
    tick(2);
    expectItem("R10", KIND_STALL, 1'b1);
    expectItem("R10", KIND_STALL, 1'b0);
    // Stall needs a transaction (R12)
    extReadyPin = 1'b0;
    tick(4);
    xferActive = 1'b0;
    tick(1);
    expectItem("R12", KIND_STALL, 1'b0);
    xferActive = 1'b1;
    tick(1);
    expectItem("R12", KIND_STALL, 1'b1);
    // Inverted ready polarity (R7)
    cfgReadyInv = 1'b1;
    tick(4);
    expectItem("R7", KIND_STALL, 1'b0);
    extReadyPin = 1'b1;
    tick(3);
    expectItem("R7", KIND_STALL, 1'b1);
    // Ready handling disabled (R8)
    cfgReadyEn = 1'b0;
    tick(1);
    expectItem("R8", KIND_STALL, 1'b0);
    extReadyPin = 1'b0;
    tick(3);
    expectItem("R8", KIND_STALL, 1'b0);
    cfgReadyInv = 1'b0;
    tick(3);
    expectItem("R8", KIND_STALL, 1'b0);
    tick(2);
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule